// File: doc/BRIEF.md
# Hiccup Overcurrent Protection Sequencer

This block sits beside each output channel of a dual supply and turns a digital overload comparator into the channel's output enable, a current-limit-active indication and an overload status flag. A configuration bit picks one of two protection styles. In the hiccup style the channel is switched off for a long rest window as soon as an overload is seen. It is then brought back under current limit for a short retry window. The fault flag only clears once a retry window completes with no overload. In the clamp style the output stays on: the flag and the limit indication simply follow the overload comparator.

All timing comes from a slow timebase tick, nominally 1 kHz. The rest and retry windows are parameters counted in ticks, with defaults of 900 and 20 ticks, which gives a 920 ms cycle. The channel enable and a soft-start-done input gate the sequencer. While the channel is disabled everything is held cleared. While soft-start is still running, the output is on and overloads are not acted on.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: While `chan_en` is low at a clock edge, from that edge on `out_en`, `ilim_act` and `olf` are all 0, and any partly counted window is discarded, so the next rest window lasts the full `OFF_TICKS` ticks.
- R2: While `chan_en` is high and `ss_done` is low, `out_en` is 1 and `olf` is 0 from the next edge on, whatever `ovl` does.
- R3: In hiccup mode (`static_mode` = 0) with the channel enabled, soft-start done and no fault pending, `ovl` high at an edge makes `out_en` 0 and `olf` 1 right after that edge.
- R4: The rest window ends on the `OFF_TICKS`-th edge at which `tick` is high. Until then `out_en` stays 0, and cycles without a tick do not advance it.
- R5: During the retry window `out_en`, `ilim_act` and `olf` are all 1. The window ends on the `ON_TICKS`-th edge at which `tick` is high.
- R6: If `ovl` was high at any edge of the retry window, including its final edge, the sequencer goes back to the rest window: `out_en` 0 and `olf` 1.
- R7: If the retry window ends with no overload seen, `out_en` is 1 and `olf` and `ilim_act` are 0 right after the final edge.
- R8: In clamp mode (`static_mode` = 1) `out_en` stays 1, and `olf` and `ilim_act` equal the `ovl` value sampled at the previous edge.
- R9: A change of `static_mode` in any state of the other mode moves the sequencer to the monitoring state of the new mode on that edge: `out_en` 1, the fault flag dropped, and no timer running.

Overload sensing itself, the soft-start counter and the timebase divider are outside the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase pulse, one clock wide, counts window time |
| chan_en | input | 1 | Channel enable; low forces the idle state |
| ss_done | input | 1 | High once the channel's soft-start has finished |
| static_mode | input | 1 | 1 selects clamp mode, 0 selects hiccup mode |
| ovl | input | 1 | Overload comparator output |
| out_en | output | 1 | Enable for the channel's converter and pass stage |
| ilim_act | output | 1 | Current limiting is active |
| olf | output | 1 | Overload status flag |

## Verification
All three outputs are decoded from state registers, so every result is due in the cycle right after the edge that samples its cause. A trip, a window end, a mode change or a disable each show on the first sample after that edge. The clamp-mode flag trails `ovl` by exactly one edge. The bench drives every input 2 ns after a rising edge and samples 2 ns after the following edge. Each check is therefore placed at a known edge count after its stimulus. The windows are counted in tick pulses that the bench issues one at a time, with idle cycles in between to show that only ticks count.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SOFT   = 3'd1,
    ST_RUN    = 3'd2,
    ST_REST   = 3'd3,
    ST_RETRY  = 3'd4,
    ST_CLAMP  = 3'd5
  } ocp_state_e;

  function automatic logic st_drives_output(input ocp_state_e s);
    return (s == ST_SOFT) || (s == ST_RUN) || (s == ST_RETRY) || (s == ST_CLAMP);
  endfunction

  function automatic logic st_is_timed(input ocp_state_e s);
    return (s == ST_REST) || (s == ST_RETRY);
  endfunction

  function automatic logic st_is_hiccup(input ocp_state_e s);
    return (s == ST_RUN) || (s == ST_REST) || (s == ST_RETRY);
  endfunction

  function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/ocp_win_timer.sv
module ocp_win_timer #(
  parameter int unsigned OFF_TICKS = 900,
  parameter int unsigned ON_TICKS  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic sel_on,
  input  logic tick,
  output logic expire
);
  localparam int unsigned CW = ocp_pkg::cnt_width(OFF_TICKS, ON_TICKS);
  localparam logic [CW-1:0] OFF_LAST = CW'(OFF_TICKS - 1);
  localparam logic [CW-1:0] ON_LAST  = CW'(ON_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last   = sel_on ? ON_LAST : OFF_LAST;
  assign expire = run && tick && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (restart)       cnt_q <= '0;
    else if (run && tick)   cnt_q <= expire ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/ocp_seq_fsm.sv
module ocp_seq_fsm
  import ocp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_en,
  input  logic       ss_done,
  input  logic       static_mode,
  input  logic       ovl,
  input  logic       expire,
  output ocp_state_e st_q,
  output logic       tmr_restart,
  output logic       tmr_run,
  output logic       tmr_sel_on,
  output logic       clamp_q,
  output logic       seen_q
);
  ocp_state_e st_n;
  logic       retry_fail;

  assign retry_fail = seen_q || ovl;

  always_comb begin
    st_n = st_q;
    if (!chan_en)      st_n = ST_IDLE;
    else if (!ss_done) st_n = ST_SOFT;
    else if (static_mode) st_n = ST_CLAMP;
    else begin
      unique case (st_q)
        ST_RUN:   st_n = ovl ? ST_REST : ST_RUN;
        ST_REST:  st_n = expire ? ST_RETRY : ST_REST;
        ST_RETRY: st_n = expire ? (retry_fail ? ST_REST : ST_RUN) : ST_RETRY;
        default:  st_n = ST_RUN;
      endcase
    end
  end

  assign tmr_restart = (st_n != st_q);
  assign tmr_run     = st_is_timed(st_q);
  assign tmr_sel_on  = (st_q == ST_RETRY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      clamp_q <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      clamp_q <= (st_n == ST_CLAMP) && ovl;
      seen_q  <= (st_q == ST_RETRY) && (st_n == ST_RETRY) && (seen_q || ovl);
    end
  end
endmodule

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl
  import ocp_pkg::*;
#(
  parameter int unsigned OFF_TICKS = 900,
  parameter int unsigned ON_TICKS  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic chan_en,
  input  logic ss_done,
  input  logic static_mode,
  input  logic ovl,
  output logic out_en,
  output logic ilim_act,
  output logic olf
);
  ocp_state_e st_q;
  logic win_expire;
  logic tmr_restart, tmr_run, tmr_sel_on;
  logic clamp_q, seen_q;

  ocp_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .ss_done(ss_done),
    .static_mode(static_mode), .ovl(ovl), .expire(win_expire),
    .st_q(st_q), .tmr_restart(tmr_restart), .tmr_run(tmr_run),
    .tmr_sel_on(tmr_sel_on), .clamp_q(clamp_q), .seen_q(seen_q)
  );

  ocp_win_timer #(.OFF_TICKS(OFF_TICKS), .ON_TICKS(ON_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .restart(tmr_restart), .run(tmr_run),
    .sel_on(tmr_sel_on), .tick(tick), .expire(win_expire)
  );

  assign out_en   = st_drives_output(st_q);
  assign ilim_act = (st_q == ST_RETRY) || ((st_q == ST_CLAMP) && clamp_q);
  assign olf      = (st_q == ST_REST) || (st_q == ST_RETRY) || ((st_q == ST_CLAMP) && clamp_q);
endmodule

// File: rtl/ocp_hiccup_chk.sv
module ocp_hiccup_chk
  import ocp_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       chan_en,
  input logic       ss_done,
  input logic       static_mode,
  input logic       ovl,
  input logic       out_en,
  input logic       ilim_act,
  input logic       olf,
  input ocp_state_e st_q,
  input logic       win_expire,
  input logic       seen_q
);
  logic live_hiccup;
  assign live_hiccup = chan_en && ss_done && !static_mode;

  a_r1_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (!out_en && !ilim_act && !olf));

  a_r2_soft_on: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && !ss_done) |=> (out_en && !olf));

  a_r3_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (live_hiccup && st_q == ST_RUN && ovl) |=> (!out_en && olf));

  a_r4_rest_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (live_hiccup && st_q == ST_REST && !tick) |=> (!out_en && olf));

  a_r5_retry_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RETRY) |-> (out_en && ilim_act && olf));

  a_r6_retry_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (live_hiccup && st_q == ST_RETRY && win_expire && (ovl || seen_q)) |=> (!out_en && olf));

  a_r7_retry_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (live_hiccup && st_q == ST_RETRY && win_expire && !ovl && !seen_q) |=> (out_en && !olf && !ilim_act));

  a_r8_clamp_on: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && ss_done && static_mode) |=> (out_en && (olf == $past(ovl))));

  a_r9_to_hiccup: assert property (@(posedge clk) disable iff (!rst_n)
    (live_hiccup && st_q == ST_CLAMP) |=> (out_en && !olf));
endmodule

bind ocp_hiccup_ctrl ocp_hiccup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .chan_en(chan_en), .ss_done(ss_done),
  .static_mode(static_mode), .ovl(ovl), .out_en(out_en), .ilim_act(ilim_act),
  .olf(olf), .st_q(st_q), .win_expire(win_expire), .seen_q(seen_q)
);

// File: tb/tb_ocp_hiccup_ctrl.sv
`timescale 1ns/1ps
module tb_ocp_hiccup_ctrl;
  localparam int unsigned OFF_T = 6;
  localparam int unsigned ON_T  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, chan_en = 1'b0, ss_done = 1'b0, static_mode = 1'b0, ovl = 1'b0;
  logic out_en, ilim_act, olf;
  int   n_chk = 0;
  int   n_err = 0;

  always #10 clk = ~clk;

  ocp_hiccup_ctrl #(.OFF_TICKS(OFF_T), .ON_TICKS(ON_T)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .chan_en(chan_en), .ss_done(ss_done),
    .static_mode(static_mode), .ovl(ovl), .out_en(out_en), .ilim_act(ilim_act), .olf(olf)
  );

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic tick_once();
    tick = 1'b1; step(); tick = 1'b0;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic outs(input string req, input logic e_en, input logic e_lim, input logic e_olf);
    chk(req, "out_en", out_en, e_en);
    chk(req, "ilim_act", ilim_act, e_lim);
    chk(req, "olf", olf, e_olf);
  endtask

  task automatic go_run();
    chan_en = 1'b1; ss_done = 1'b1; static_mode = 1'b0; ovl = 1'b0;
    step();
  endtask

  task automatic trip();
    ovl = 1'b1; step(); ovl = 1'b0;
  endtask

  task automatic t_reset();
    outs("R1", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1; step(); step();
    outs("R1", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_soft();
    chan_en = 1'b1; ss_done = 1'b0; ovl = 1'b1;
    for (int i = 0; i < 4; i++) begin step(); outs("R2", 1'b1, 1'b0, 1'b0); end
    ovl = 1'b0; ss_done = 1'b1; step();
    outs("R2", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_cycle_pass();
    go_run(); outs("R3", 1'b1, 1'b0, 1'b0);
    trip(); outs("R3", 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < OFF_T - 1; i++) begin tick_once(); step(); outs("R4", 1'b0, 1'b0, 1'b1); end
    tick_once(); outs("R4", 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < ON_T - 1; i++) begin tick_once(); step(); outs("R5", 1'b1, 1'b1, 1'b1); end
    tick_once(); outs("R7", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_cycle_fail();
    go_run(); trip();
    for (int i = 0; i < OFF_T; i++) tick_once();
    outs("R5", 1'b1, 1'b1, 1'b1);
    trip(); outs("R6", 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < ON_T; i++) tick_once();
    outs("R6", 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < OFF_T; i++) tick_once();
    for (int i = 0; i < ON_T - 1; i++) tick_once();
    ovl = 1'b1; tick_once(); ovl = 1'b0;
    outs("R6", 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < OFF_T; i++) tick_once();
    for (int i = 0; i < ON_T; i++) tick_once();
    outs("R7", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_disable();
    go_run(); trip();
    for (int i = 0; i < 3; i++) tick_once();
    chan_en = 1'b0; step(); outs("R1", 1'b0, 1'b0, 1'b0);
    go_run(); outs("R1", 1'b1, 1'b0, 1'b0);
    trip();
    for (int i = 0; i < OFF_T - 1; i++) tick_once();
    outs("R1", 1'b0, 1'b0, 1'b1);
    tick_once(); outs("R4", 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < ON_T; i++) tick_once();
  endtask

  task automatic t_static();
    go_run(); static_mode = 1'b1; step(); outs("R8", 1'b1, 1'b0, 1'b0);
    ovl = 1'b1; step(); outs("R8", 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < OFF_T + 2; i++) tick_once();
    outs("R8", 1'b1, 1'b1, 1'b1);
    ovl = 1'b0; step(); outs("R8", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_mode_switch();
    go_run(); trip(); tick_once();
    static_mode = 1'b1; step(); outs("R9", 1'b1, 1'b0, 1'b0);
    ovl = 1'b1; step(); ovl = 1'b0;
    static_mode = 1'b0; step(); outs("R9", 1'b1, 1'b0, 1'b0);
    trip();
    for (int i = 0; i < OFF_T; i++) tick_once();
    static_mode = 1'b1; step(); outs("R9", 1'b1, 1'b0, 1'b0);
    static_mode = 1'b0; step();
  endtask

  initial begin
    #2;
    t_reset();
    t_soft();
    t_cycle_pass();
    t_cycle_fail();
    t_disable();
    t_static();
    t_mode_switch();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule